// File: doc/BRIEF.md
# Bus Clock Divider and Peripheral Clock Gate

This block sits next to the system clock and produces clock-enable ticks, not new clocks. One programmable power-of-two divider makes the main bus tick from the system clock. Two further dividers each count main-bus ticks to make the two peripheral-bus ticks. Every downstream register stage then advances only in cycles where its bus tick is high.

For each peripheral the block holds a run enable bit and a sleep enable bit. It combines them with a sleep-mode indication into a per-peripheral gate, and outputs that gate ANDed with the peripheral's bus tick. The flash slot starts with its run enable set. The two SRAM slots are always clocked outside sleep, and their sleep enables start set. A gate only changes at the clock edge that closes a tick of its own bus, so a gated enable never produces a partial pulse.

A register access aimed at a peripheral passes through an access guard. When the target's gate is off, the access is refused: read data is zero and no write is forwarded.

Top module: `busclk_gate`

## Requirements
- R1: `ahb_tick` is high once every 2^k system clock cycles, where k is `ahb_code` for codes 0..9; codes above 9 act as 9 (divide by 512). With code 0 it is high in every cycle.
- R2: Each peripheral-bus tick is high once every 2^m main-bus ticks, where m is its 3-bit code for 0..4; codes above 4 act as 4 (divide by 16). A peripheral-bus tick is high only in a cycle where `ahb_tick` is high.
- R3: A new divider code takes effect only after the divided period in progress has completed. A change of `ahb_code` from 2 to 0 one cycle after a tick gives one gap of 4 cycles, then a tick in every cycle.
- R4: After reset, the run enables are set only for index 0 (flash), and the sleep enables are set only for indices 1 and 2 (the SRAMs). With all codes at 0 and outside sleep, `periph_ck_en` reads 8'h07.
- R5: Outside sleep mode, indices 1 and 2 are enabled whatever their run enable bits hold.
- R6: In sleep mode (`sleep_mode`=1), a peripheral is enabled only if both its effective run enable and its sleep enable are set. A sleep enable bit has no effect while its run enable is clear.
- R7: A peripheral's gate changes only at the clock edge that ends a cycle in which its bus tick is high. `periph_ck_en[i]` is high only in such tick cycles. Indices 0..2 use the main bus, 3..4 the first peripheral bus, and 5..7 the second.
- R8: When `acc_req` is high and the gate of `acc_sel` is on, the access is accepted: `acc_ok`=1, `acc_rdata`=`periph_rdata`, `fwd_wr`=`acc_wr` and `fwd_wdata`=`acc_wdata`. Otherwise `acc_ok`=0 and `acc_rdata`, `fwd_wr` and `fwd_wdata` are all zero.
- R9: `cfg_run_wr` loads the run enables from `cfg_wdata`, and `cfg_sleep_wr` loads the sleep enables, both at the next clock edge (bit i belongs to index i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ahb_code | input | 4 | Main-bus divide code, divide by 2^code |
| apb1_code | input | 3 | First peripheral-bus divide code |
| apb2_code | input | 3 | Second peripheral-bus divide code |
| sleep_mode | input | 1 | High while the system is in sleep mode |
| cfg_run_wr | input | 1 | Load the run enables from cfg_wdata |
| cfg_sleep_wr | input | 1 | Load the sleep enables from cfg_wdata |
| cfg_wdata | input | 8 | New enable bits, one per peripheral |
| acc_req | input | 1 | Register access request |
| acc_sel | input | 3 | Index of the peripheral addressed |
| acc_wr | input | 1 | Access is a write |
| acc_wdata | input | 32 | Write data from the bus |
| periph_rdata | input | 32 | Read data from the addressed peripheral |
| ahb_tick | output | 1 | Main-bus clock enable |
| apb1_tick | output | 1 | First peripheral-bus clock enable |
| apb2_tick | output | 1 | Second peripheral-bus clock enable |
| periph_ck_en | output | 8 | Gated clock enable per peripheral |
| acc_ok | output | 1 | Access accepted |
| acc_rdata | output | 32 | Read data returned to the bus |
| fwd_wr | output | 1 | Write strobe forwarded to the peripheral |
| fwd_wdata | output | 32 | Write data forwarded to the peripheral |

## Verification
The ticks and the access-guard outputs are combinational from state. The bench reads them half a cycle after the edge that follows an input change. A configuration or sleep-mode change reaches the enable register at one edge and the gate at the edge closing the next bus tick. With all codes at 0 that is the edge after, so the bench waits two edges before comparing `periph_ck_en` with its model. Divider periods are measured as the gap between tick samples, taken only after two boundaries have passed, so the old code cannot leak into the measurement. The boundary-timing tests instead count cycles from a known tick and sample at the exact cycle computed for the change.

// File: rtl/busclk_pkg.sv
// Shared types for the bus clock divider and peripheral gate.
// Assumes peripheral-to-bus mapping is given as 2 bits per peripheral.
package busclk_pkg;
    typedef enum logic [1:0] {
        BUS_MAIN = 2'd0,
        BUS_PER1 = 2'd1,
        BUS_PER2 = 2'd2
    } bus_id_e;
endpackage

// File: rtl/busclk_divider.sv
// Power-of-two tick divider. Counts input ticks and emits one output tick
// every 2^code input ticks. Codes above MAX_LOG clamp to MAX_LOG. The code is
// sampled only at the period boundary, so a change applies to the next period.
// Assumes CODE_W is wide enough to hold MAX_LOG.
module busclk_divider #(
    parameter int CODE_W  = 4,
    parameter int MAX_LOG = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [CODE_W-1:0] code,
    output logic              tick_out
);
    localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;
    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_LOG);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  reload;
    logic [CODE_W-1:0] log_eff;
    logic [CNT_W:0]    span;

    // Clamp the code and derive the reload value for the next period.
    always_comb begin
        log_eff = (code > CODE_MAX) ? CODE_MAX : code;
        span    = (CNT_W+1)'(1) << log_eff;
        reload  = CNT_W'(span - 1'b1);
    end

    // Count down on each input tick; reload at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

    assign tick_out = tick_in && (cnt_q == '0);
endmodule

// File: rtl/busclk_periph_gate.sv
// Per-peripheral enable storage and gate. Holds one run and one sleep enable
// bit, forms the wanted gate state from them and the sleep indication, and
// copies it into the gate register only at the edge closing a bus tick.
// Assumes bus_tick is a single-cycle-wide enable from this block's dividers.
module busclk_periph_gate #(
    parameter bit RUN_RST    = 1'b0,
    parameter bit SLEEP_RST  = 1'b0,
    parameter bit ALWAYS_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_tick,
    input  logic sleep_mode,
    input  logic run_wr,
    input  logic sleep_wr,
    input  logic wbit,
    output logic gate_q
);
    logic run_q;
    logic sleep_q;
    logic run_eff;
    logic want;

    // Enable bit storage, loaded by configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= RUN_RST;
            sleep_q <= SLEEP_RST;
        end else begin
            if (run_wr)   run_q   <= wbit;
            if (sleep_wr) sleep_q <= wbit;
        end
    end

    // Sleep enable only counts on top of an effective run enable.
    always_comb begin
        run_eff = run_q | ALWAYS_RUN;
        want    = sleep_mode ? (run_eff & sleep_q) : run_eff;
    end

    // Gate follows the wanted state only at a bus tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= RUN_RST | ALWAYS_RUN;
        end else if (bus_tick) begin
            gate_q <= want;
        end
    end
endmodule

// File: rtl/busclk_access_guard.sv
// Register access filter. Lets an access through only when the addressed
// peripheral's gate is on; otherwise returns zero and suppresses the write.
// Assumes periph_rdata is already muxed for the addressed peripheral.
module busclk_access_guard #(
    parameter int NPERIPH = 8,
    parameter int SEL_W   = 3,
    parameter int DW      = 32
) (
    input  logic [NPERIPH-1:0] gate,
    input  logic               acc_req,
    input  logic [SEL_W-1:0]   acc_sel,
    input  logic               acc_wr,
    input  logic [DW-1:0]      acc_wdata,
    input  logic [DW-1:0]      periph_rdata,
    output logic               acc_ok,
    output logic [DW-1:0]      acc_rdata,
    output logic               fwd_wr,
    output logic [DW-1:0]      fwd_wdata
);
    logic in_range;

    // Decide acceptance and zero every path of a refused access.
    always_comb begin
        in_range  = int'(acc_sel) < NPERIPH;
        acc_ok    = acc_req && in_range && gate[acc_sel];
        acc_rdata = acc_ok ? periph_rdata : '0;
        fwd_wr    = acc_ok && acc_wr;
        fwd_wdata = acc_ok ? acc_wdata : '0;
    end
endmodule

// File: rtl/busclk_gate.sv
// Top: main-bus divider, two peripheral-bus dividers fed by the main-bus tick,
// one gate per peripheral on its mapped bus, and the access guard.
// Assumes all ticks are clock enables in the system clock domain.
module busclk_gate
    import busclk_pkg::*;
#(
    parameter int NPERIPH     = 8,
    parameter int DW          = 32,
    parameter int AHB_CODE_W  = 4,
    parameter int AHB_MAX_LOG = 9,
    parameter int APB_CODE_W  = 3,
    parameter int APB_MAX_LOG = 4,
    parameter int FLASH_IDX   = 0,
    parameter logic [NPERIPH-1:0]   SRAM_MASK = NPERIPH'(6),
    parameter logic [2*NPERIPH-1:0] BUS_MAP   = (2*NPERIPH)'(16'hA940),
    localparam int SEL_W = $clog2(NPERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AHB_CODE_W-1:0] ahb_code,
    input  logic [APB_CODE_W-1:0] apb1_code,
    input  logic [APB_CODE_W-1:0] apb2_code,
    input  logic                  sleep_mode,
    input  logic                  cfg_run_wr,
    input  logic                  cfg_sleep_wr,
    input  logic [NPERIPH-1:0]    cfg_wdata,
    input  logic                  acc_req,
    input  logic [SEL_W-1:0]      acc_sel,
    input  logic                  acc_wr,
    input  logic [DW-1:0]         acc_wdata,
    input  logic [DW-1:0]         periph_rdata,
    output logic                  ahb_tick,
    output logic                  apb1_tick,
    output logic                  apb2_tick,
    output logic [NPERIPH-1:0]    periph_ck_en,
    output logic                  acc_ok,
    output logic [DW-1:0]         acc_rdata,
    output logic                  fwd_wr,
    output logic [DW-1:0]         fwd_wdata
);
    localparam logic [NPERIPH-1:0] RUN_RST   = NPERIPH'(1) << FLASH_IDX;
    localparam logic [NPERIPH-1:0] SLEEP_RST = SRAM_MASK;

    logic [NPERIPH-1:0] gate_state;
    logic [NPERIPH-1:0] bus_tick_vec;

    busclk_divider #(.CODE_W(AHB_CODE_W), .MAX_LOG(AHB_MAX_LOG)) u_div_main (
        .clk(clk), .rst_n(rst_n), .tick_in(1'b1), .code(ahb_code), .tick_out(ahb_tick)
    );

    busclk_divider #(.CODE_W(APB_CODE_W), .MAX_LOG(APB_MAX_LOG)) u_div_per1 (
        .clk(clk), .rst_n(rst_n), .tick_in(ahb_tick), .code(apb1_code), .tick_out(apb1_tick)
    );

    busclk_divider #(.CODE_W(APB_CODE_W), .MAX_LOG(APB_MAX_LOG)) u_div_per2 (
        .clk(clk), .rst_n(rst_n), .tick_in(ahb_tick), .code(apb2_code), .tick_out(apb2_tick)
    );

    for (genvar i = 0; i < NPERIPH; i++) begin : g_per
        localparam logic [1:0] BSEL = BUS_MAP[2*i +: 2];

        // Pick the tick of the bus this peripheral hangs on.
        assign bus_tick_vec[i] = (BSEL == BUS_PER1) ? apb1_tick :
                                 (BSEL == BUS_PER2) ? apb2_tick : ahb_tick;

        busclk_periph_gate #(
            .RUN_RST   (RUN_RST[i]),
            .SLEEP_RST (SLEEP_RST[i]),
            .ALWAYS_RUN(SRAM_MASK[i])
        ) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_tick  (bus_tick_vec[i]),
            .sleep_mode(sleep_mode),
            .run_wr    (cfg_run_wr),
            .sleep_wr  (cfg_sleep_wr),
            .wbit      (cfg_wdata[i]),
            .gate_q    (gate_state[i])
        );

        assign periph_ck_en[i] = gate_state[i] & bus_tick_vec[i];
    end

    busclk_access_guard #(.NPERIPH(NPERIPH), .SEL_W(SEL_W), .DW(DW)) u_guard (
        .gate        (gate_state),
        .acc_req     (acc_req),
        .acc_sel     (acc_sel),
        .acc_wr      (acc_wr),
        .acc_wdata   (acc_wdata),
        .periph_rdata(periph_rdata),
        .acc_ok      (acc_ok),
        .acc_rdata   (acc_rdata),
        .fwd_wr      (fwd_wr),
        .fwd_wdata   (fwd_wdata)
    );
endmodule

// File: rtl/busclk_gate_chk.sv
// Property checker for busclk_gate, attached by bind below.
// Assumes the synchronous active-low reset is held across at least one edge.
module busclk_gate_chk #(
    parameter int NPERIPH    = 8,
    parameter int DW         = 32,
    parameter int AHB_CODE_W = 4,
    parameter logic [NPERIPH-1:0] SRAM_MASK = NPERIPH'(6)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [AHB_CODE_W-1:0] ahb_code,
    input logic                  sleep_mode,
    input logic                  ahb_tick,
    input logic                  apb1_tick,
    input logic                  apb2_tick,
    input logic [NPERIPH-1:0]    bus_tick_vec,
    input logic [NPERIPH-1:0]    gate_state,
    input logic                  acc_req,
    input logic                  acc_ok,
    input logic [DW-1:0]         acc_rdata,
    input logic                  fwd_wr,
    input logic [DW-1:0]         fwd_wdata
);
    // R1
    main_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_code == '0 && $past(ahb_code) == '0 && $past(ahb_tick)) |-> ahb_tick);

    // R2
    per1_in_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apb1_tick |-> ahb_tick);

    // R2
    per2_in_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apb2_tick |-> ahb_tick);

    // R8
    refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |-> (acc_rdata == '0 && !fwd_wr && fwd_wdata == '0));

    // R8
    ok_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> acc_req);

    for (genvar i = 0; i < NPERIPH; i++) begin : g_p
        // R7
        gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_tick_vec[i] |=> $stable(gate_state[i]));

        if (SRAM_MASK[i]) begin : g_sram
            // R5
            sram_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(sleep_mode) && $past(bus_tick_vec[i])) |-> gate_state[i]);
        end
    end
endmodule

bind busclk_gate busclk_gate_chk #(
    .NPERIPH(NPERIPH), .DW(DW), .AHB_CODE_W(AHB_CODE_W), .SRAM_MASK(SRAM_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ahb_code(ahb_code), .sleep_mode(sleep_mode),
    .ahb_tick(ahb_tick), .apb1_tick(apb1_tick), .apb2_tick(apb2_tick),
    .bus_tick_vec(bus_tick_vec), .gate_state(gate_state), .acc_req(acc_req),
    .acc_ok(acc_ok), .acc_rdata(acc_rdata), .fwd_wr(fwd_wr), .fwd_wdata(fwd_wdata)
);

// File: tb/sim_busclk_gate.sv
module sim_busclk_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ahb_code;
    logic [2:0]  apb1_code, apb2_code;
    logic        sleep_mode, cfg_run_wr, cfg_sleep_wr;
    logic [7:0]  cfg_wdata;
    logic        acc_req, acc_wr;
    logic [2:0]  acc_sel;
    logic [31:0] acc_wdata, periph_rdata;
    logic        ahb_tick, apb1_tick, apb2_tick, acc_ok, fwd_wr;
    logic [7:0]  periph_ck_en;
    logic [31:0] acc_rdata, fwd_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    busclk_gate u0 (
        .clk(clk), .rst_n(rst_n), .ahb_code(ahb_code), .apb1_code(apb1_code),
        .apb2_code(apb2_code), .sleep_mode(sleep_mode), .cfg_run_wr(cfg_run_wr),
        .cfg_sleep_wr(cfg_sleep_wr), .cfg_wdata(cfg_wdata), .acc_req(acc_req),
        .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .periph_rdata(periph_rdata), .ahb_tick(ahb_tick), .apb1_tick(apb1_tick),
        .apb2_tick(apb2_tick), .periph_ck_en(periph_ck_en), .acc_ok(acc_ok),
        .acc_rdata(acc_rdata), .fwd_wr(fwd_wr), .fwd_wdata(fwd_wdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected enables from the requirement text (R4..R6).
    function automatic logic [7:0] exp_en(input logic [7:0] run, input logic [7:0] slp,
                                          input logic sm);
        logic [7:0] r;
        r = run | 8'b0000_0110;
        return sm ? (r & slp) : r;
    endfunction

    function automatic int exp_gap(input int which, input int a, input int p);
        int ga;
        ga = 1 << ((a > 9) ? 9 : a);
        return (which == 0) ? ga : ga << ((p > 4) ? 4 : p);
    endfunction

    function automatic logic tick_of(input int which);
        return (which == 0) ? ahb_tick : (which == 1) ? apb1_tick : apb2_tick;
    endfunction

    task automatic meas(input int which, output int g);
        int n;
        do @(negedge clk); while (!tick_of(which));
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_of(which));
        g = n;
    endtask

    // R9: load run then sleep enables, set sleep mode, let the gates settle.
    task automatic setup(input logic [7:0] run, input logic [7:0] slp, input logic sm);
        @(negedge clk); cfg_run_wr = 1'b1; cfg_wdata = run;
        @(negedge clk); cfg_run_wr = 1'b0; cfg_sleep_wr = 1'b1; cfg_wdata = slp;
        @(negedge clk); cfg_sleep_wr = 1'b0; sleep_mode = sm;
        repeat (2) @(negedge clk);
    endtask

    task automatic access_check(input logic [7:0] en, input string req);
        logic [2:0] s;
        logic ex;
        s = 3'($urandom_range(0, 7));
        acc_req = 1'b1; acc_sel = s; acc_wr = 1'($urandom);
        acc_wdata = $urandom; periph_rdata = $urandom;
        #1;
        ex = en[s];
        check(acc_ok == ex, req, "acc_ok", 64'(acc_ok), 64'(ex));
        check(acc_rdata == (ex ? periph_rdata : 32'h0), req, "acc_rdata",
              64'(acc_rdata), 64'(ex ? periph_rdata : 32'h0));
        check(fwd_wr == (ex & acc_wr) && fwd_wdata == (ex ? acc_wdata : 32'h0), req,
              "fwd", {31'h0, fwd_wr, fwd_wdata}, {31'h0, ex & acc_wr, ex ? acc_wdata : 32'h0});
    endtask

    task automatic div_test(input int a, input int p1, input int p2);
        int g;
        @(negedge clk);
        ahb_code = 4'(a); apb1_code = 3'(p1); apb2_code = 3'(p2);
        meas(1, g); meas(1, g);
        meas(0, g);
        check(g == exp_gap(0, a, 0), "R1", $sformatf("main gap code %0d", a), 64'(g), 64'(exp_gap(0, a, 0)));
        meas(1, g);
        check(g == exp_gap(1, a, p1), "R2", $sformatf("per1 gap %0d/%0d", a, p1), 64'(g), 64'(exp_gap(1, a, p1)));
        meas(2, g); meas(2, g);
        check(g == exp_gap(2, a, p2), "R2", $sformatf("per2 gap %0d/%0d", a, p2), 64'(g), 64'(exp_gap(2, a, p2)));
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0; ahb_code = '0; apb1_code = '0; apb2_code = '0;
        sleep_mode = 1'b0; cfg_run_wr = 1'b0; cfg_sleep_wr = 1'b0; cfg_wdata = '0;
        acc_req = 1'b0; acc_sel = '0; acc_wr = 1'b0; acc_wdata = '0; periph_rdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        check(periph_ck_en == 8'h07, "R4", "reset enables", 64'(periph_ck_en), 64'h07);
        check(ahb_tick == 1'b1, "R1", "code 0 tick", 64'(ahb_tick), 64'h1);
        acc_req = 1'b1; acc_sel = 3'd3; periph_rdata = 32'hCAFE_0001; #1;
        check(acc_ok == 1'b0 && acc_rdata == 0, "R4", "access to off periph",
              {acc_ok, acc_rdata}, 64'h0);
        acc_sel = 3'd0; #1;
        check(acc_ok == 1'b1 && acc_rdata == 32'hCAFE_0001, "R4", "flash access at reset",
              {acc_ok, acc_rdata}, {1'b1, 32'hCAFE_0001});
        acc_req = 1'b0; #1;
        check(acc_ok == 1'b0, "R8", "no request", 64'(acc_ok), 64'h0);
        // R4 R6: sleep defaults keep only the SRAMs
        @(negedge clk); sleep_mode = 1'b1;
        repeat (2) @(negedge clk);
        check(periph_ck_en == 8'h06, "R4", "sleep defaults", 64'(periph_ck_en), 64'h06);
        // R5 SRAMs forced on outside sleep
        setup(8'h00, 8'h00, 1'b0);
        check(periph_ck_en == 8'h06, "R5", "run bits clear", 64'(periph_ck_en), 64'h06);
        // R6 directed
        setup(8'hFF, 8'h0A, 1'b1);
        check(periph_ck_en == 8'h0A, "R6", "sleep mask", 64'(periph_ck_en), 64'h0A);
        setup(8'h00, 8'hF8, 1'b1);
        check(periph_ck_en == 8'h00, "R6", "sleep bit without run", 64'(periph_ck_en), 64'h00);
        access_check(8'h00, "R8");
        // R9 R6 R8 random
        for (int t = 0; t < 30; t++) begin
            logic [7:0] rn, sl;
            logic sm;
            rn = 8'($urandom); sl = 8'($urandom); sm = 1'($urandom);
            setup(rn, sl, sm);
            check(periph_ck_en == exp_en(rn, sl, sm), sm ? "R6" : "R9", "random enables",
                  64'(periph_ck_en), 64'(exp_en(rn, sl, sm)));
            access_check(exp_en(rn, sl, sm), "R8");
        end
        acc_req = 1'b0;
        // R1 R2 directed and random dividers
        div_test(0, 0, 0);
        div_test(1, 2, 3);
        div_test(9, 4, 4);
        div_test(12, 7, 5);
        for (int t = 0; t < 8; t++)
            div_test($urandom_range(0, 4), $urandom_range(0, 7), $urandom_range(0, 7));
        // R3 code change mid-period
        begin
            int n;
            @(negedge clk); ahb_code = 4'd2; apb1_code = '0; apb2_code = '0;
            repeat (12) @(negedge clk);
            while (!ahb_tick) @(negedge clk);
            @(negedge clk); ahb_code = 4'd0;
            n = 1;
            do begin @(negedge clk); n++; end while (!ahb_tick);
            check(n == 4, "R3", "gap finishing old period", 64'(n), 64'd4);
            @(negedge clk);
            check(ahb_tick == 1'b1, "R3", "new period in force", 64'(ahb_tick), 64'h1);
        end
        // R7 gate change waits for the bus tick boundary
        begin
            bit early_bad;
            setup(8'h01, 8'h00, 1'b0);
            @(negedge clk); ahb_code = 4'd3;
            repeat (20) @(negedge clk);
            while (!ahb_tick) @(negedge clk);
            @(negedge clk);
            acc_req = 1'b1; acc_sel = 3'd0; cfg_run_wr = 1'b1; cfg_wdata = 8'h00;
            @(negedge clk); cfg_run_wr = 1'b0;
            early_bad = 1'b0;
            for (int k = 2; k <= 7; k++) begin
                if (!acc_ok || periph_ck_en[0]) early_bad = 1'b1;
                @(negedge clk);
            end
            check(!early_bad, "R7", "gate held before boundary", 64'(early_bad), 64'h0);
            check(ahb_tick && periph_ck_en[0] && acc_ok, "R7", "last tick still enabled",
                  {ahb_tick, periph_ck_en[0], acc_ok}, 64'h7);
            @(negedge clk);
            check(!acc_ok && !periph_ck_en[0], "R7", "gate off after boundary",
                  {acc_ok, periph_ck_en[0]}, 64'h0);
        end
        done = 1'b1;
        report();
    end
endmodule